// File: doc/BRIEF.md
# Exact/Approximate Integer Arithmetic Execute Unit

This unit is the arithmetic slice of a 32-bit RISC-V execute stage. It takes a raw instruction word and the two source register values, which are already read, and decodes the register-register arithmetic group. The ordinary RV32I register operations and the RV32M low-word multiply always run on exact logic. Three extra encodings reuse the normal arithmetic opcode with the top funct7 bit set. They ask for addition, subtraction or multiplication on cheaper, approximate hardware. Error-tolerant loops, such as distance sums or neural-network dot products, can then trade accuracy for switching activity. Code outside those loops keeps exact results.

The approximate operators sit behind fixed module boundaries, so another approximate design can replace them without touching the decoder. The default adder is a lower-part OR adder: the low 8 bits are ORed and the upper 24 bits are added exactly with no carry from below. The default multiplier clears the low 4 bits of each operand and then multiplies. All outputs come from one register stage.

Top module: `approx_alu_stage`

## Requirements
- R1: Only opcode 0110011 in instruction bits [6:0] is decoded; any other opcode gives valid_o = 0.
- R2: Exact ADD (funct7 0000000, funct3 000) and SUB (funct7 0100000, funct3 000) return rs1+rs2 and rs1-rs2 modulo 2^32, with approx_o = 0.
- R3: An approximate instruction has funct3 000 and the exact funct7 with bit 6 (instruction bit 31) inverted: 1000000 is approximate add, 1100000 is approximate subtract, 1000001 is approximate multiply. These encodings, and only these, set approx_o = 1.
- R4: Approximate add gives result[7:0] = rs1[7:0] | rs2[7:0] and result[31:8] = rs1[31:8] + rs2[31:8]. No carry passes from the low part into the upper part.
- R5: Approximate subtract gives result[7:0] = rs1[7:0] | ~rs2[7:0] and result[31:8] = rs1[31:8] + ~rs2[31:8] + 1, modulo 2^24.
- R6: Approximate multiply returns the low 32 bits of (rs1 with bits [3:0] cleared) times (rs2 with bits [3:0] cleared).
- R7: Exact MUL (funct7 0000001, funct3 000) returns the low 32 bits of the signed product.
- R8: The other exact register operations use funct7 0000000 with funct3 values 001 SLL, 010 SLT, 011 SLTU, 100 XOR, 101 SRL, 110 OR and 111 AND, plus funct7 0100000 with funct3 101 for SRA. These operations are never approximate, and shifts use rs2[4:0].
- R9: Any other funct7/funct3 pair under the arithmetic opcode is illegal, including an approximate funct7 with funct3 other than 000. An illegal instruction gives valid_o = 0, result_o = 0, rd_o = 0 and approx_o = 0.
- R10: Outputs change exactly one rising clock edge after the inputs are presented. A synchronous active-high reset clears every output to 0.
- R11: When valid_o = 1, rd_o equals instruction bits [11:7] from the cycle the inputs were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| op_a_i | input | 32 | Value of source register 1 |
| op_b_i | input | 32 | Value of source register 2 |
| result_o | output | 32 | Registered result |
| rd_o | output | 5 | Registered destination register index |
| valid_o | output | 1 | Registered legal-instruction flag |
| approx_o | output | 1 | Registered flag: the result came from an approximate operator |

## Verification
Result, destination index, valid flag and approximate flag are all due at the first rising edge after an instruction is applied, and they must not change before that edge. The bench drives each instruction on a falling edge. It first samples just after driving, to confirm the previous outputs still hold. It then samples at the next falling edge, half a period after the only register has loaded. Reset checks are also sampled one falling edge after the reset edge.

// File: rtl/approx_alu_pkg.sv
package approx_alu_pkg;

  localparam logic [6:0] OPC_ARITH_REG = 7'b0110011;

  localparam logic [6:0] F7_BASE   = 7'b0000000;
  localparam logic [6:0] F7_ALT    = 7'b0100000;
  localparam logic [6:0] F7_MULDIV = 7'b0000001;
  localparam logic [6:0] F7_FLIP   = 7'b1000000;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_MUL, OP_SLL, OP_SLT, OP_SLTU,
    OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
  } alu_op_e;

  typedef struct packed {
    alu_op_e    op;
    logic       approx;
    logic       legal;
    logic [4:0] rd;
  } dec_t;

  function automatic logic [31:0] signed_mul_low(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] full;
    full = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return full[31:0];
  endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import approx_alu_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic [6:0] funct7_i,
  input  logic [4:0] rd_i,
  output dec_t       dec_o
);
  logic [9:0] key;
  assign key = {funct7_i, funct3_i};

  always_comb begin
    dec_o.op     = OP_NONE;
    dec_o.approx = 1'b0;
    if (opcode_i == OPC_ARITH_REG) begin
      case (key)
        {F7_BASE, 3'd0}:             dec_o.op = OP_ADD;
        {F7_BASE, 3'd1}:             dec_o.op = OP_SLL;
        {F7_BASE, 3'd2}:             dec_o.op = OP_SLT;
        {F7_BASE, 3'd3}:             dec_o.op = OP_SLTU;
        {F7_BASE, 3'd4}:             dec_o.op = OP_XOR;
        {F7_BASE, 3'd5}:             dec_o.op = OP_SRL;
        {F7_BASE, 3'd6}:             dec_o.op = OP_OR;
        {F7_BASE, 3'd7}:             dec_o.op = OP_AND;
        {F7_ALT, 3'd0}:              dec_o.op = OP_SUB;
        {F7_ALT, 3'd5}:              dec_o.op = OP_SRA;
        {F7_MULDIV, 3'd0}:           dec_o.op = OP_MUL;
        {F7_BASE ^ F7_FLIP, 3'd0}:   begin dec_o.op = OP_ADD; dec_o.approx = 1'b1; end
        {F7_ALT ^ F7_FLIP, 3'd0}:    begin dec_o.op = OP_SUB; dec_o.approx = 1'b1; end
        {F7_MULDIV ^ F7_FLIP, 3'd0}: begin dec_o.op = OP_MUL; dec_o.approx = 1'b1; end
        default:                     dec_o.op = OP_NONE;
      endcase
    end
    dec_o.legal = (dec_o.op != OP_NONE);
    dec_o.rd    = dec_o.legal ? rd_i : 5'd0;
  end
endmodule

// File: rtl/approx_adder.sv
module approx_adder #(
  parameter int W        = 32,
  parameter int LOW_BITS = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  localparam int HI_BITS = W - LOW_BITS;

  function automatic logic [HI_BITS-1:0] upper_add(input logic [HI_BITS-1:0] x,
                                                   input logic [HI_BITS-1:0] y,
                                                   input logic c);
    return x + y + {{(HI_BITS-1){1'b0}}, c};
  endfunction

  assign sum_o[LOW_BITS-1:0] = a_i[LOW_BITS-1:0] | b_i[LOW_BITS-1:0];
  assign sum_o[W-1:LOW_BITS] = upper_add(a_i[W-1:LOW_BITS], b_i[W-1:LOW_BITS], cin_i);
endmodule

// File: rtl/approx_mult.sv
module approx_mult #(
  parameter int W          = 32,
  parameter int TRUNC_BITS = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_o
);
  localparam logic [W-1:0] KEEP_MASK = {{(W-TRUNC_BITS){1'b1}}, {TRUNC_BITS{1'b0}}};

  function automatic logic [W-1:0] trunc_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] xm, ym;
    xm = x & KEEP_MASK;
    ym = y & KEEP_MASK;
    return xm * ym;
  endfunction

  assign prod_o = trunc_mul(a_i, b_i);
endmodule

// File: rtl/exact_alu.sv
module exact_alu
  import approx_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int SH_BITS = $clog2(W);
  logic [SH_BITS-1:0] shamt;
  assign shamt = b_i[SH_BITS-1:0];

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_MUL:  res_o = signed_mul_low(a_i, b_i);
      OP_SLL:  res_o = a_i << shamt;
      OP_SLT:  res_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      OP_SLTU: res_o = {{(W-1){1'b0}}, a_i < b_i};
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SRL:  res_o = a_i >> shamt;
      OP_SRA:  res_o = $unsigned($signed(a_i) >>> shamt);
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/approx_alu_stage.sv
module approx_alu_stage
  import approx_alu_pkg::*;
#(
  parameter int LOA_LOW_BITS  = 8,
  parameter int MUL_TRUNC_BITS = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr_i,
  input  logic [31:0] op_a_i,
  input  logic [31:0] op_b_i,
  output logic [31:0] result_o,
  output logic [4:0]  rd_o,
  output logic        valid_o,
  output logic        approx_o
);
  localparam int W = 32;

  dec_t         dec;
  logic         dec_legal;
  logic         use_approx_path;
  logic         approx_is_sub;
  logic [W-1:0] approx_b;
  logic [W-1:0] approx_sum;
  logic [W-1:0] approx_prod;
  logic [W-1:0] exact_res;
  logic [W-1:0] next_result;
  logic         unused_src_idx;

  assign unused_src_idx = ^instr_i[24:15];

  alu_decode u_dec (
    .opcode_i (instr_i[6:0]),
    .funct3_i (instr_i[14:12]),
    .funct7_i (instr_i[31:25]),
    .rd_i     (instr_i[11:7]),
    .dec_o    (dec)
  );

  assign dec_legal       = dec.legal;
  assign use_approx_path = dec.legal && dec.approx;
  assign approx_is_sub   = (dec.op == OP_SUB);
  assign approx_b        = approx_is_sub ? ~op_b_i : op_b_i;

  approx_adder #(.W(W), .LOW_BITS(LOA_LOW_BITS)) u_aadd (
    .a_i   (op_a_i),
    .b_i   (approx_b),
    .cin_i (approx_is_sub),
    .sum_o (approx_sum)
  );

  approx_mult #(.W(W), .TRUNC_BITS(MUL_TRUNC_BITS)) u_amul (
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .prod_o (approx_prod)
  );

  exact_alu #(.W(W)) u_exact (
    .op_i  (dec.op),
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .res_o (exact_res)
  );

  always_comb begin
    if (!dec_legal)
      next_result = '0;
    else if (use_approx_path)
      next_result = (dec.op == OP_MUL) ? approx_prod : approx_sum;
    else
      next_result = exact_res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      rd_o     <= '0;
      valid_o  <= 1'b0;
      approx_o <= 1'b0;
    end else begin
      result_o <= next_result;
      rd_o     <= dec.rd;
      valid_o  <= dec_legal;
      approx_o <= use_approx_path;
    end
  end
endmodule

// File: rtl/approx_alu_stage_checker.sv
module approx_alu_stage_checker #(
  parameter int LOW_BITS = 8
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr_i,
  input logic [31:0] op_a_i,
  input logic [31:0] op_b_i,
  input logic [31:0] result_o,
  input logic [4:0]  rd_o,
  input logic        valid_o,
  input logic        approx_o,
  input logic        dec_legal,
  input logic        use_approx_path
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic is_arith, is_exact_add, is_approx_add;
  assign is_arith      = (instr_i[6:0] == 7'b0110011);
  assign is_exact_add  = is_arith && instr_i[31:25] == 7'b0000000 && instr_i[14:12] == 3'd0;
  assign is_approx_add = is_arith && instr_i[31:25] == 7'b1000000 && instr_i[14:12] == 3'd0;

  a_r9_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (result_o == 32'd0 && rd_o == 5'd0 && !approx_o));

  a_r3_approx_is_valid: assert property (@(posedge clk) disable iff (rst)
    approx_o |-> valid_o);

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (valid_o == $past(dec_legal) && approx_o == $past(use_approx_path)));

  a_r1_foreign_opcode: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!is_arith)) |-> !valid_o);

  a_r2_exact_add: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(is_exact_add)) |-> (result_o == $past(op_a_i + op_b_i) && !approx_o));

  a_r4_loa_low: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(is_approx_add)) |->
      (result_o[LOW_BITS-1:0] == $past(op_a_i[LOW_BITS-1:0] | op_b_i[LOW_BITS-1:0])));

  a_r11_rd_field: assert property (@(posedge clk) disable iff (rst)
    (past_ok && valid_o) |-> rd_o == $past(instr_i[11:7]));
endmodule

bind approx_alu_stage approx_alu_stage_checker #(.LOW_BITS(LOA_LOW_BITS)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .instr_i         (instr_i),
  .op_a_i          (op_a_i),
  .op_b_i          (op_b_i),
  .result_o        (result_o),
  .rd_o            (rd_o),
  .valid_o         (valid_o),
  .approx_o        (approx_o),
  .dec_legal       (dec_legal),
  .use_approx_path (use_approx_path)
);

// File: tb/test_approx_alu_stage.sv
module test_approx_alu_stage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0;
  logic [31:0] a = 32'd0;
  logic [31:0] b = 32'd0;
  logic [31:0] result;
  logic [4:0]  rd;
  logic        valid, approx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  approx_alu_stage i_approx_alu_stage (
    .clk(clk), .rst(rst), .instr_i(instr), .op_a_i(a), .op_b_i(b),
    .result_o(result), .rd_o(rd), .valid_o(valid), .approx_o(approx)
  );

  typedef struct packed {
    logic [6:0]  f7;
    logic [2:0]  f3;
    logic [6:0]  opc;
    logic [31:0] va;
    logic [31:0] vb;
  } vec_t;

  localparam vec_t VEC [20] = '{
    '{7'h00, 3'd0, 7'h33, 32'h1234_5678, 32'h0FED_CBA9},
    '{7'h20, 3'd0, 7'h33, 32'h0000_0005, 32'h0000_0009},
    '{7'h01, 3'd0, 7'h33, 32'hFFFF_FFF9, 32'h0000_1234},
    '{7'h40, 3'd0, 7'h33, 32'h00AB_CDEF, 32'h0012_3487},
    '{7'h40, 3'd0, 7'h33, 32'hFFFF_FF80, 32'h0000_0080},
    '{7'h60, 3'd0, 7'h33, 32'h0001_0000, 32'h0000_0033},
    '{7'h60, 3'd0, 7'h33, 32'h8000_0000, 32'hFFFF_FFFF},
    '{7'h41, 3'd0, 7'h33, 32'h0000_ABCD, 32'h0000_0F1F},
    '{7'h41, 3'd0, 7'h33, 32'hFFFF_FFFF, 32'h0000_0031},
    '{7'h00, 3'd1, 7'h33, 32'h8000_0001, 32'h0000_0021},
    '{7'h00, 3'd2, 7'h33, 32'hFFFF_FFFE, 32'h0000_0001},
    '{7'h00, 3'd3, 7'h33, 32'hFFFF_FFFE, 32'h0000_0001},
    '{7'h00, 3'd4, 7'h33, 32'hF0F0_F0F0, 32'h0FF0_0FF0},
    '{7'h00, 3'd5, 7'h33, 32'h8000_0000, 32'h0000_001F},
    '{7'h20, 3'd5, 7'h33, 32'h8000_0000, 32'h0000_0010},
    '{7'h00, 3'd6, 7'h33, 32'h1200_0034, 32'h0056_7800},
    '{7'h00, 3'd7, 7'h33, 32'hFFFF_0000, 32'h00FF_FF00},
    '{7'h40, 3'd3, 7'h33, 32'h0000_0011, 32'h0000_0022},
    '{7'h00, 3'd0, 7'h13, 32'h0000_0011, 32'h0000_0022},
    '{7'h21, 3'd0, 7'h33, 32'h0000_0011, 32'h0000_0022}
  };

  function automatic logic [31:0] enc(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [4:0] rdi, input logic [6:0] opc);
    return {f7, 5'd7, 5'd3, f3, rdi, opc};
  endfunction

  function automatic void model(input logic [31:0] ins, input logic [31:0] x,
                                input logic [31:0] y, output logic [31:0] r,
                                output logic v, output logic ap, output logic [4:0] rdx);
    longint p;
    logic [31:0] xt, yt;
    r = 0; v = 1; ap = 0;
    if (ins[6:0] != 7'h33) v = 0;
    else case ({ins[31:25], ins[14:12]})
      {7'h00, 3'd0}: r = x + y;
      {7'h20, 3'd0}: r = x - y;
      {7'h01, 3'd0}: begin p = longint'($signed(x)) * longint'($signed(y)); r = p[31:0]; end
      {7'h40, 3'd0}: begin
        ap = 1;
        for (int i = 0; i < 8; i++) r[i] = x[i] | y[i];
        r[31:8] = x[31:8] + y[31:8];
      end
      {7'h60, 3'd0}: begin
        ap = 1;
        for (int i = 0; i < 8; i++) r[i] = x[i] | ~y[i];
        r[31:8] = x[31:8] + ~y[31:8] + 24'd1;
      end
      {7'h41, 3'd0}: begin
        ap = 1;
        xt = (x >> 4) << 4; yt = (y >> 4) << 4;
        r = xt * yt;
      end
      {7'h00, 3'd1}: r = x << y[4:0];
      {7'h00, 3'd2}: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      {7'h00, 3'd3}: r = (x < y) ? 32'd1 : 32'd0;
      {7'h00, 3'd4}: r = x ^ y;
      {7'h00, 3'd5}: r = x >> y[4:0];
      {7'h20, 3'd5}: r = $unsigned($signed(x) >>> y[4:0]);
      {7'h00, 3'd6}: r = x | y;
      {7'h00, 3'd7}: r = x & y;
      default: v = 0;
    endcase
    rdx = v ? ins[11:7] : 5'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    instr = ins; a = x; b = y;
  endtask

  task automatic check_all(input string req, input logic [31:0] er, input logic ev,
                           input logic eap, input logic [4:0] erd);
    chk(req, result, er);
    chk(req, {27'd0, rd}, {27'd0, erd});
    chk(req, {31'd0, valid}, {31'd0, ev});
    chk(req, {31'd0, approx}, {31'd0, eap});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] er;
    logic ev, eap;
    logic [4:0] erd;

    // R10: reset state
    instr = enc(7'h00, 3'd0, 5'd9, 7'h33); a = 32'd1; b = 32'd2;
    repeat (3) @(negedge clk);
    check_all("R10 reset", 32'd0, 1'b0, 1'b0, 5'd0);
    rst = 1'b0;

    // Table walk: R1..R9, R11
    foreach (VEC[k]) begin
      logic [31:0] ins;
      ins = enc(VEC[k].f7, VEC[k].f3, 5'(k + 1), VEC[k].opc);
      apply(ins, VEC[k].va, VEC[k].vb);
      @(negedge clk);
      model(ins, VEC[k].va, VEC[k].vb, er, ev, eap, erd);
      check_all("R1-table R2 R3 R4 R5 R6 R7 R8 R9 R11", er, ev, eap, erd);
    end

    // R2: wraparound on exact add
    apply(enc(7'h00, 3'd0, 5'd4, 7'h33), 32'hFFFF_FFFF, 32'h1);
    @(negedge clk); check_all("R2 add wrap", 32'h0, 1'b1, 1'b0, 5'd4);

    // R4: carry from low part dropped
    apply(enc(7'h40, 3'd0, 5'd5, 7'h33), 32'h0000_00FF, 32'h1);
    @(negedge clk); check_all("R4 loa", 32'h0000_00FF, 1'b1, 1'b1, 5'd5);

    // R5: approximate subtract
    apply(enc(7'h60, 3'd0, 5'd6, 7'h33), 32'h0000_0100, 32'h1);
    @(negedge clk); check_all("R5 asub", 32'h0000_01FE, 1'b1, 1'b1, 5'd6);

    // R6: truncated multiply
    apply(enc(7'h41, 3'd0, 5'd7, 7'h33), 32'h13, 32'h25);
    @(negedge clk); check_all("R6 amul", 32'h0000_0200, 1'b1, 1'b1, 5'd7);

    // R7: signed exact multiply
    apply(enc(7'h01, 3'd0, 5'd8, 7'h33), 32'hFFFF_FFFD, 32'h5);
    @(negedge clk); check_all("R7 mul", 32'hFFFF_FFF1, 1'b1, 1'b0, 5'd8);

    // R8: arithmetic shift uses rs2[4:0]
    apply(enc(7'h20, 3'd5, 5'd10, 7'h33), 32'h8000_0000, 32'h24);
    @(negedge clk); check_all("R8 sra", 32'hF800_0000, 1'b1, 1'b0, 5'd10);

    // R9: approximate funct7 with nonzero funct3 is illegal
    apply(enc(7'h60, 3'd5, 5'd11, 7'h33), 32'h55, 32'h1);
    @(negedge clk); check_all("R9 illegal", 32'h0, 1'b0, 1'b0, 5'd0);

    // R10: no change before the edge, new value after it
    apply(enc(7'h00, 3'd4, 5'd12, 7'h33), 32'hA5A5_0000, 32'h0000_5A5A);
    #1 check_all("R10 hold", 32'h0, 1'b0, 1'b0, 5'd0);
    @(negedge clk); check_all("R10 R11 latency", 32'hA5A5_5A5A, 1'b1, 1'b0, 5'd12);

    // R10: mid-stream synchronous reset
    apply(enc(7'h40, 3'd0, 5'd13, 7'h33), 32'h3, 32'h4);
    rst = 1'b1;
    @(negedge clk); check_all("R10 sync reset", 32'h0, 1'b0, 1'b0, 5'd0);
    rst = 1'b0;
    @(negedge clk); check_all("R3 R11 after reset", 32'h7, 1'b1, 1'b1, 5'd13);

    finish_run();
  end
endmodule